// File: doc/BRIEF.md
# SIMD/FP Transition and Saturation Event Generator

This block sits beside the retirement stage of a processor core and turns a stream of retiring-instruction descriptors into one-clock event strobes for a performance counter. Each cycle it may receive one descriptor. The descriptor carries a valid flag and flags for SIMD, floating-point, saturating and EMMS instructions. It also carries one saturated-result bit per SIMD lane.

The block keeps a single mode bit that records whether the register file is in SIMD state or in FP state. It raises a transition strobe on the first instruction of the other class, and the mode bit flips with that strobe. A counter fed by the transition strobe therefore holds an even value in SIMD state and an odd value in FP state. Three further strobes report:
- executed EMMS instructions;
- executed saturating instructions, whether or not any result saturated;
- saturating instructions in which at least one lane actually saturated, counted once per instruction however many lanes saturated.

Top module: `simd_evt_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, all four strobes are 0 and `fp_mode` is 0, which means SIMD state.
- R2: A valid instruction with only the FP flag set, retired while `fp_mode` is 0, raises `ev_transition` in the next cycle, and `fp_mode` reads 1 from that same cycle.
- R3: A valid instruction with only the SIMD flag set, retired while `fp_mode` is 1, raises `ev_transition` in the next cycle, and `fp_mode` reads 0 from that same cycle.
- R4: No transition is raised and `fp_mode` does not change for any of these instructions: one of the class the mode already holds, one with neither class flag set, or one with both class flags set.
- R5: `fp_mode` changes only in a cycle where `ev_transition` is 1, and it changes in every such cycle. The parity of the total number of transition strobes therefore equals `fp_mode`.
- R6: Every valid instruction with the saturating flag set raises `ev_sat_exec` in the next cycle, whatever its lane mask holds.
- R7: `ev_sat_hit` is 1 in the next cycle exactly when the instruction is valid, has the saturating flag set, and has at least one lane bit set. It gives one strobe per instruction, however many lanes are set. When the saturating flag is 0, the lane mask is ignored.
- R8: Every valid instruction with the EMMS flag set raises `ev_emms` in the next cycle.
- R9: A descriptor with the valid flag at 0 raises no strobe and leaves `fp_mode` unchanged, whatever its other flags are.
- R10: Each strobe lasts exactly one clock for each qualifying instruction. Qualifying instructions on consecutive cycles give strobes on consecutive cycles, and several strobes may be raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A descriptor is retiring this cycle |
| in_simd | input | 1 | The instruction is a SIMD instruction |
| in_fp | input | 1 | The instruction is a floating-point instruction |
| in_sat | input | 1 | The instruction uses saturating arithmetic (add, subtract, pack) |
| in_lane_sat | input | LANES | Per-lane flag that the lane result saturated |
| in_emms | input | 1 | The instruction is EMMS |
| ev_transition | output | 1 | Strobe: the class changed between SIMD and FP |
| ev_emms | output | 1 | Strobe: an EMMS instruction was executed |
| ev_sat_exec | output | 1 | Strobe: a saturating instruction was executed |
| ev_sat_hit | output | 1 | Strobe: a saturating instruction saturated at least one lane |
| fp_mode | output | 1 | Current mode: 0 is SIMD state, 1 is FP state |

## Verification
Two functions of this block can fall in the same cycle: the transition strobe and the saturation strobes. The bench provokes this with one descriptor that is flagged FP, saturating and EMMS at once, has lanes set, and arrives while the block is in SIMD state. It then checks that all four strobes rise together for one cycle and that `fp_mode` flips alongside them. A second case sends alternating FP and SIMD descriptors back to back. There each cycle must give its own transition strobe, and the running parity must match `fp_mode`.

// File: rtl/simd_evt_pkg.sv
package simd_evt_pkg;

  typedef enum logic {
    MODE_SIMD = 1'b0,
    MODE_FP   = 1'b1
  } mode_e;

  // True when a retired instruction moves the register file to the other class.
  function automatic logic f_crosses(input mode_e cur, input logic valid,
                                     input logic is_simd, input logic is_fp);
    logic only_simd;
    logic only_fp;
    only_simd = is_simd & ~is_fp;
    only_fp   = is_fp & ~is_simd;
    return valid & ((cur == MODE_SIMD) ? only_fp : only_simd);
  endfunction

  function automatic mode_e f_flip(input mode_e cur);
    return (cur == MODE_SIMD) ? MODE_FP : MODE_SIMD;
  endfunction

endpackage

// File: rtl/simd_mode_tracker.sv
module simd_mode_tracker
  import simd_evt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic is_simd,
  input  logic is_fp,
  output logic ev_trans,
  output logic fp_mode
);

  mode_e mode_q;
  logic  cross_now;

  assign cross_now = f_crosses(mode_q, valid, is_simd, is_fp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_SIMD;
      ev_trans <= 1'b0;
    end else begin
      ev_trans <= cross_now;
      if (cross_now) mode_q <= f_flip(mode_q);
    end
  end

  assign fp_mode = (mode_q == MODE_FP);

  AST_TRANS_FLIPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ev_trans |-> fp_mode != $past(fp_mode)); // R5

  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !ev_trans |-> $stable(fp_mode)); // R4

  AST_TRANS_NEEDS_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trans |-> $past(valid && (is_simd ^ is_fp))); // R2

endmodule

// File: rtl/simd_sat_events.sv
module simd_sat_events #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             is_sat,
  input  logic [LANES-1:0] lane_sat,
  output logic             ev_exec,
  output logic             ev_hit
);

  // Collapse any number of saturated lanes into a single flag.
  function automatic logic f_any_lane(input logic [LANES-1:0] m);
    logic r;
    r = 1'b0;
    for (int i = 0; i < LANES; i++) r = r | m[i];
    return r;
  endfunction

  logic exec_now;
  logic hit_now;

  assign exec_now = valid & is_sat;
  assign hit_now  = exec_now & f_any_lane(lane_sat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_exec <= 1'b0;
      ev_hit  <= 1'b0;
    end else begin
      ev_exec <= exec_now;
      ev_hit  <= hit_now;
    end
  end

  AST_HIT_NEEDS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |-> ev_exec); // R7

  AST_EXEC_FOLLOWS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(valid && is_sat) |-> ev_exec); // R6

  AST_NO_HIT_CLEAN_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lane_sat == '0) |-> !ev_hit); // R7

endmodule

// File: rtl/simd_emms_event.sv
module simd_emms_event (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic is_emms,
  output logic ev_emms
);

  logic emms_now;
  assign emms_now = valid & is_emms;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_emms <= 1'b0;
    else        ev_emms <= emms_now;
  end

  AST_EMMS_EACH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(valid && is_emms) |-> ev_emms); // R8

endmodule

// File: rtl/simd_evt_gen.sv
module simd_evt_gen #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_simd,
  input  logic             in_fp,
  input  logic             in_sat,
  input  logic [LANES-1:0] in_lane_sat,
  input  logic             in_emms,
  output logic             ev_transition,
  output logic             ev_emms,
  output logic             ev_sat_exec,
  output logic             ev_sat_hit,
  output logic             fp_mode
);

  logic trans_w;
  logic emms_w;
  logic exec_w;
  logic hit_w;
  logic mode_w;

  simd_mode_tracker u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (in_valid),
    .is_simd (in_simd),
    .is_fp   (in_fp),
    .ev_trans(trans_w),
    .fp_mode (mode_w)
  );

  simd_sat_events #(.LANES(LANES)) u_sat (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (in_valid),
    .is_sat  (in_sat),
    .lane_sat(in_lane_sat),
    .ev_exec (exec_w),
    .ev_hit  (hit_w)
  );

  simd_emms_event u_emms (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid  (in_valid),
    .is_emms(in_emms),
    .ev_emms(emms_w)
  );

  assign ev_transition = trans_w;
  assign ev_emms       = emms_w;
  assign ev_sat_exec   = exec_w;
  assign ev_sat_hit    = hit_w;
  assign fp_mode       = mode_w;

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> !(trans_w || emms_w || exec_w || hit_w)); // R9

  AST_IDLE_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(in_valid) |-> $stable(mode_w)); // R9

endmodule

// File: tb/simd_evt_gen_test.sv
module simd_evt_gen_test;
  localparam int PERIOD = 10;
  localparam int LANES  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0, in_simd = 1'b0, in_fp = 1'b0;
  logic             in_sat = 1'b0, in_emms = 1'b0;
  logic [LANES-1:0] in_lane_sat = '0;
  logic ev_transition, ev_emms, ev_sat_exec, ev_sat_hit, fp_mode;

  simd_evt_gen #(.LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_simd(in_simd),
    .in_fp(in_fp), .in_sat(in_sat), .in_lane_sat(in_lane_sat), .in_emms(in_emms),
    .ev_transition(ev_transition), .ev_emms(ev_emms), .ev_sat_exec(ev_sat_exec),
    .ev_sat_hit(ev_sat_hit), .fp_mode(fp_mode)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int trans_count = 0;
  bit model_fp = 1'b0;
  bit running = 1'b0;
  bit done = 1'b0;
  logic [4:0] exp_q[$];
  string      tag_q[$];

  // Expected word: {transition, emms, sat_exec, sat_hit, fp_mode after}
  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic issue(input string tag, input bit v, input bit s, input bit f,
                       input bit sat, input logic [LANES-1:0] m, input bit e);
    bit t;
    @(negedge clk);
    in_valid = v; in_simd = s; in_fp = f; in_sat = sat; in_lane_sat = m; in_emms = e;
    t = v && (model_fp ? (s && !f) : (f && !s));
    if (t) begin model_fp = !model_fp; trans_count++; end
    exp_q.push_back({t, v && e, v && sat, v && sat && (m != '0), model_fp});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    if (running) begin
      #(PERIOD/4);
      if (exp_q.size() > 0) begin
        logic [4:0] e;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(tg, {ev_transition, ev_emms, ev_sat_exec, ev_sat_hit, fp_mode}, e);
      end
    end
  end

  initial begin
    #(PERIOD*5000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(PERIOD*3 + 1);
    check("R1 in reset", {ev_transition, ev_emms, ev_sat_exec, ev_sat_hit, fp_mode}, 5'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {ev_transition, ev_emms, ev_sat_exec, ev_sat_hit, fp_mode}, 5'b0);
    running = 1'b1;
    issue("R4 simd in simd mode", 1, 1, 0, 0, 4'h0, 0);
    issue("R2 fp enters fp",      1, 0, 1, 0, 4'h0, 0);
    issue("R4 fp again",          1, 0, 1, 0, 4'h0, 0);
    issue("R4 neither class",     1, 0, 0, 0, 4'h0, 0);
    issue("R4 both class flags",  1, 1, 1, 0, 4'h0, 0);
    issue("R9 invalid simd",      0, 1, 0, 1, 4'hF, 1);
    issue("R3 simd leaves fp",    1, 1, 0, 0, 4'h0, 0);
    issue("R6 sat no lanes",      1, 1, 0, 1, 4'h0, 0);
    issue("R7 sat three lanes",   1, 1, 0, 1, 4'h7, 0);
    issue("R7 sat one lane",      1, 1, 0, 1, 4'h8, 0);
    issue("R7 mask without sat",  1, 1, 0, 0, 4'hF, 0);
    issue("R8 emms",              1, 1, 0, 0, 4'h0, 1);
    issue("R10 idle after emms",  0, 0, 0, 0, 4'h0, 0);
    issue("R10 all strobes together", 1, 0, 1, 1, 4'h2, 1);
    issue("R10 b2b simd",         1, 1, 0, 0, 4'h0, 0);
    issue("R10 b2b fp",           1, 0, 1, 0, 4'h0, 0);
    issue("R10 b2b simd 2",       1, 1, 0, 0, 4'h0, 0);
    issue("R10 b2b fp 2",         1, 0, 1, 0, 4'h0, 0);
    issue("R9 invalid simd in fp", 0, 1, 0, 0, 4'h0, 0);
    issue("R10 idle end",         0, 0, 0, 0, 4'h0, 0);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (fp_mode !== trans_count[0]) begin
      fails++;
      $display("FAIL R5 parity: actual %b expected %b", fp_mode, trans_count[0]);
    end
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10 drain: actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule